// File: doc/BRIEF.md
# ADC Parallel Output Formatter

This block sits between a 14-bit converter core and the pad ring. Each conversion delivers a raw code and an input-valid strobe. The block saturates the code at positive full scale and raises an over-range flag when it does. It holds the latest sample and sends it out on the parallel data pins, with a forwarded output clock, the over-range pin, an output-enable for the pad drivers and a resolved pad-standard selection.

The internal clock `clk` runs at twice the output-clock rate. Each output-clock period therefore covers two `clk` cycles, a low phase and a high phase. A small state machine sequences these phases. It has three states. `ST_OFF` holds all outputs quiet with the drivers disabled. `ST_LO` is the low phase of the output clock. `ST_HI` is the high phase.

The machine has these transitions:
- Leaving reset, `ST_OFF` moves to `ST_LO` ("wake") on the first edge where `pwr_down` is low.
- `ST_LO` moves to `ST_HI` ("rise").
- `ST_HI` moves to `ST_LO` ("fall").
- Any state moves to `ST_OFF` ("sleep") on an edge where `pwr_down` is high.

Every entry into `ST_LO` is a launch. At a launch the output word, the over-range pin and the data-rate mode are reloaded together.

In single data rate mode all pins carry the whole word. In double data rate mode only the even pins carry data, and two bit groups share them across the two phases.

Top module: `adc_out_fmt`

## Requirements
- R1: While `rst_n` is low, `oe`, `oclk`, `oovr` and every `odata` pin are 0, and the state machine is in `ST_OFF`.
- R2: With `pwr_down` low, the first edge after reset enters `ST_LO` (`oclk`=0, `oe`=1). After that, `oclk` toggles on every `clk` edge.
- R3: In single data rate mode (`ddr_sel`=0 at launch), `odata[i]` equals bit i of the launched word during both phases of the period.
- R4: In double data rate mode (`ddr_sel`=1 at launch), pin 2k carries word bit 2k+1 while `oclk` is 0 and word bit 2k while `oclk` is 1. Every odd pin is driven 0 in both phases.
- R5: A sample whose valid strobe is high in the cycle before a launch is the word launched at that launch. When no valid sample arrives, the next launch repeats the last held word.
- R6: A raw code (15 bits, unsigned) of 0x3FFF or above is output as 0x3FFF, with `oovr`=1. A code below 0x3FFF passes unchanged, with `oovr`=0. `oovr` changes only at a launch.
- R7: `ddr_sel` is sampled only at a launch. A change during a period takes effect at the next period.
- R8: With `cfg_ovr_en`=0, `pad_std` follows `strap_pad`: 00 gives 0 (CMOS), 01 or 11 gives 1 (LVDS, normal current), and 10 gives 2 (LVDS, reduced current).
- R9: With `cfg_ovr_en`=1, `pad_std` follows `cfg_pad` with the same encoding (0, 1 or 2, where 3 reads as 1), regardless of the strap.
- R10: An edge with `pwr_down`=1 enters `ST_OFF`, which forces `oe`, `oclk`, `oovr` and `odata` to 0. The held sample survives. After release, the next edge launches it again from `ST_LO`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock, twice the output-clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Qualifies `smp_raw` this cycle |
| smp_raw | input | 15 | Unsigned raw code with one headroom bit |
| ddr_sel | input | 1 | 1 selects double data rate, 0 single |
| strap_pad | input | 2 | Strapped pad-standard code |
| cfg_ovr_en | input | 1 | Register override enable for the pad standard |
| cfg_pad | input | 2 | Register pad-standard code |
| pwr_down | input | 1 | Nap or sleep request from the power controller |
| oclk | output | 1 | Forwarded output clock |
| odata | output | 14 | Parallel data pins |
| oovr | output | 1 | Over-range pin |
| oe | output | 1 | Pad driver enable |
| pad_std | output | 2 | Resolved pad standard |

## Verification
A corrupt phase state shows up on `oclk` within one `clk` cycle, as a repeated level or a missing toggle. A wrong launch condition shows up at the next low phase, as a stale word or a change in the middle of a period. If the data-rate mode is latched at the wrong time, the high phase after a mid-period `ddr_sel` change shows the other pin pattern. If the power-down path fails, a driven pin or a raised `oe` appears one edge after `pwr_down` rises.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_LO  = 2'd1,
        ST_HI  = 2'd2
    } fmt_state_t;

    localparam logic [1:0] PAD_CMOS     = 2'd0;
    localparam logic [1:0] PAD_LVDS_NOM = 2'd1;
    localparam logic [1:0] PAD_LVDS_LOW = 2'd2;
endpackage

// File: rtl/fmt_clamp.sv
module fmt_clamp #(
    parameter int W = 14
) (
    input  logic [W:0]   raw,
    output logic [W-1:0] code,
    output logic         ovr
);
    localparam logic [W:0] FULL = {1'b0, {W{1'b1}}};

    always_comb begin
        if (raw >= FULL) begin
            code = {W{1'b1}};
            ovr  = 1'b1;
        end else begin
            code = raw[W-1:0];
            ovr  = 1'b0;
        end
    end
endmodule

// File: rtl/fmt_phase_fsm.sv
module fmt_phase_fsm
    import fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_down,
    output fmt_state_t state,
    output logic       launch
);
    fmt_state_t state_d;

    always_comb begin
        state_d = state;
        if (pwr_down) begin
            state_d = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:  state_d = ST_LO;
                ST_LO:   state_d = ST_HI;
                ST_HI:   state_d = ST_LO;
                default: state_d = ST_OFF;
            endcase
        end
    end

    assign launch = (state_d == ST_LO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_d;
    end

    assert_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LO && !pwr_down) |=> (state == ST_HI));
    assert_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI && !pwr_down) |=> (state == ST_LO));
    assert_sleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (state == ST_OFF));
endmodule

// File: rtl/fmt_lane_mux.sv
module fmt_lane_mux #(
    parameter int W = 14
) (
    input  logic [W-1:0] word,
    input  logic         ddr,
    input  logic         phase_hi,
    input  logic         en,
    output logic [W-1:0] pins
);
    localparam int PAIRS = W / 2;

    for (genvar k = 0; k < PAIRS; k++) begin : g_pair
        always_comb begin
            if (!en) begin
                pins[2*k]   = 1'b0;
                pins[2*k+1] = 1'b0;
            end else if (ddr) begin
                pins[2*k]   = phase_hi ? word[2*k] : word[2*k+1];
                pins[2*k+1] = 1'b0;
            end else begin
                pins[2*k]   = word[2*k];
                pins[2*k+1] = word[2*k+1];
            end
        end
    end
endmodule

// File: rtl/fmt_pad_sel.sv
module fmt_pad_sel
    import fmt_pkg::*;
(
    input  logic [1:0] strap,
    input  logic       ovr_en,
    input  logic [1:0] cfg,
    output logic [1:0] pad_std
);
    logic [1:0] src;

    always_comb begin
        src = ovr_en ? cfg : strap;
        unique case (src)
            2'b00:   pad_std = PAD_CMOS;
            2'b10:   pad_std = PAD_LVDS_LOW;
            default: pad_std = PAD_LVDS_NOM;
        endcase
    end
endmodule

// File: rtl/adc_out_fmt.sv
module adc_out_fmt
    import fmt_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp_valid,
    input  logic [W:0]   smp_raw,
    input  logic         ddr_sel,
    input  logic [1:0]   strap_pad,
    input  logic         cfg_ovr_en,
    input  logic [1:0]   cfg_pad,
    input  logic         pwr_down,
    output logic         oclk,
    output logic [W-1:0] odata,
    output logic         oovr,
    output logic         oe,
    output logic [1:0]   pad_std
);
    localparam logic [W-1:0] ODD_MASK = {(W/2){2'b10}};
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    fmt_state_t   state;
    logic         launch;
    logic [W-1:0] clamp_code;
    logic         clamp_ovr;
    logic [W-1:0] hold_q, word_q;
    logic         hold_ovr_q, ovr_q, ddr_q;

    initial begin
        if (W % 2 != 0) $error("W must be even");
    end

    fmt_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
        .state(state), .launch(launch)
    );

    fmt_clamp #(.W(W)) u_clamp (
        .raw(smp_raw), .code(clamp_code), .ovr(clamp_ovr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q     <= '0;
            hold_ovr_q <= 1'b0;
        end else if (smp_valid) begin
            hold_q     <= clamp_code;
            hold_ovr_q <= clamp_ovr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            ovr_q  <= 1'b0;
            ddr_q  <= 1'b0;
        end else if (launch) begin
            word_q <= smp_valid ? clamp_code : hold_q;
            ovr_q  <= smp_valid ? clamp_ovr : hold_ovr_q;
            ddr_q  <= ddr_sel;
        end
    end

    always_comb begin
        oe   = (state != ST_OFF);
        oclk = (state == ST_HI);
        oovr = oe & ovr_q;
    end

    fmt_lane_mux #(.W(W)) u_mux (
        .word(word_q), .ddr(ddr_q), .phase_hi(oclk), .en(oe), .pins(odata)
    );

    fmt_pad_sel u_pad (
        .strap(strap_pad), .ovr_en(cfg_ovr_en), .cfg(cfg_pad), .pad_std(pad_std)
    );

    assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (odata == '0 && !oclk && !oovr));
    assert_odd_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && ddr_q) |-> ((odata & ODD_MASK) == '0));
    assert_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !ddr_q && oovr) |-> (odata == ALL_ONES));
    assert_period_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI) |-> (word_q == $past(word_q) && ovr_q == $past(ovr_q)));
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI) |-> (ddr_q == $past(ddr_q)));
endmodule

// File: tb/sim_adc_out_fmt.sv
module sim_adc_out_fmt;
    localparam int W = 14;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         smp_valid = 1'b0;
    logic [W:0]   smp_raw = '0;
    logic         ddr_sel = 1'b0;
    logic [1:0]   strap_pad = 2'b00;
    logic         cfg_ovr_en = 1'b0;
    logic [1:0]   cfg_pad = 2'b00;
    logic         pwr_down = 1'b0;
    logic         oclk, oovr, oe;
    logic [W-1:0] odata;
    logic [1:0]   pad_std;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    adc_out_fmt #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_raw(smp_raw),
        .ddr_sel(ddr_sel), .strap_pad(strap_pad), .cfg_ovr_en(cfg_ovr_en),
        .cfg_pad(cfg_pad), .pwr_down(pwr_down), .oclk(oclk), .odata(odata),
        .oovr(oovr), .oe(oe), .pad_std(pad_std)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_lo(input logic [W-1:0] w);
        logic [W-1:0] e = '0;
        for (int k = 0; k < W / 2; k++) e[2*k] = w[2*k+1];
        return e;
    endfunction

    function automatic logic [W-1:0] exp_hi(input logic [W-1:0] w);
        logic [W-1:0] e = '0;
        for (int k = 0; k < W / 2; k++) e[2*k] = w[2*k];
        return e;
    endfunction

    task automatic wait_hi();
        @(negedge clk);
        while (oclk !== 1'b1) @(negedge clk);
    endtask

    // Drive one sample so that it launches at the next edge, then check both phases.
    task automatic send(input logic [W:0] raw, input logic ddr,
                        input logic [W-1:0] w, input logic ov, input string req);
        wait_hi();
        smp_raw = raw; smp_valid = 1'b1; ddr_sel = ddr;
        @(negedge clk);
        smp_valid = 1'b0;
        chk({req, " low phase clk"}, oclk, 0);
        chk({req, " low phase data"}, odata, ddr ? exp_lo(w) : w);
        chk({req, " low phase ovr"}, oovr, ov);
        @(negedge clk);
        chk({req, " high phase data"}, odata, ddr ? exp_hi(w) : w);
        chk({req, " high phase ovr"}, oovr, ov);
    endtask

    task automatic t_reset();
        chk("R1 oe", oe, 0);
        chk("R1 oclk", oclk, 0);
        chk("R1 data", odata, 0);
        chk("R1 ovr", oovr, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 first phase low", oclk, 0);
        chk("R2 oe after wake", oe, 1);
        @(negedge clk);
        chk("R2 toggles high", oclk, 1);
        @(negedge clk);
        chk("R2 toggles low", oclk, 0);
    endtask

    task automatic t_sdr();
        send(15'h1234, 1'b0, 14'h1234, 1'b0, "R3 sdr pattern a");
        send(15'h2AD5, 1'b0, 14'h2AD5, 1'b0, "R3 sdr pattern b");
        send(15'h0000, 1'b0, 14'h0000, 1'b0, "R3 sdr zero");
    endtask

    task automatic t_ddr();
        send(15'h2AAA, 1'b1, 14'h2AAA, 1'b0, "R4 ddr alt a");
        send(15'h1555, 1'b1, 14'h1555, 1'b0, "R4 ddr alt b");
        send(15'h0F0F, 1'b1, 14'h0F0F, 1'b0, "R4 ddr mixed");
    endtask

    task automatic t_hold();
        send(15'h0ABC, 1'b0, 14'h0ABC, 1'b0, "R5 capture");
        wait_hi();
        @(negedge clk);
        chk("R5 held word repeats", odata, 14'h0ABC);
    endtask

    task automatic t_clamp();
        send(15'h3FFE, 1'b0, 14'h3FFE, 1'b0, "R6 below full scale");
        send(15'h3FFF, 1'b0, 14'h3FFF, 1'b1, "R6 at full scale");
        send(15'h4000, 1'b0, 14'h3FFF, 1'b1, "R6 clamp above");
        send(15'h7FFF, 1'b0, 14'h3FFF, 1'b1, "R6 clamp max");
        // Over-range arriving mid-period must not reach the pin before the launch.
        send(15'h0100, 1'b0, 14'h0100, 1'b0, "R6 clear");
        smp_raw = 15'h7000; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        if (oclk === 1'b1) chk("R6 ovr waits for launch", oovr, 0);
        else chk("R6 ovr waits for launch", oovr, 1);
    endtask

    task automatic t_mode_latch();
        wait_hi();
        smp_raw = 15'h2AAA; smp_valid = 1'b1; ddr_sel = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        ddr_sel = 1'b0;
        chk("R7 low phase keeps ddr", odata, exp_lo(14'h2AAA));
        @(negedge clk);
        chk("R7 high phase keeps ddr", odata, exp_hi(14'h2AAA));
        @(negedge clk);
        chk("R7 new mode next period", odata, 14'h2AAA);
    endtask

    task automatic t_pad();
        cfg_ovr_en = 1'b0;
        strap_pad = 2'b00; #1 chk("R8 strap low cmos", pad_std, 0);
        strap_pad = 2'b01; #1 chk("R8 strap float lvds", pad_std, 1);
        strap_pad = 2'b10; #1 chk("R8 strap high lvds low", pad_std, 2);
        strap_pad = 2'b11; #1 chk("R8 strap code 3", pad_std, 1);
        cfg_ovr_en = 1'b1;
        strap_pad = 2'b00;
        cfg_pad = 2'b10; #1 chk("R9 override low current", pad_std, 2);
        cfg_pad = 2'b01; #1 chk("R9 override normal", pad_std, 1);
        strap_pad = 2'b10;
        cfg_pad = 2'b00; #1 chk("R9 override cmos", pad_std, 0);
        cfg_pad = 2'b11; #1 chk("R9 override code 3", pad_std, 1);
        cfg_ovr_en = 1'b0;
    endtask

    task automatic t_power();
        send(15'h1357, 1'b0, 14'h1357, 1'b0, "R10 pre sample");
        pwr_down = 1'b1;
        @(negedge clk);
        chk("R10 oe off", oe, 0);
        chk("R10 clk off", oclk, 0);
        chk("R10 data off", odata, 0);
        chk("R10 ovr off", oovr, 0);
        @(negedge clk);
        chk("R10 stays off", oe, 0);
        pwr_down = 1'b0;
        @(negedge clk);
        chk("R10 wake low phase", oclk, 0);
        chk("R10 wake oe", oe, 1);
        chk("R10 held word relaunched", odata, 14'h1357);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_sdr();
        t_ddr();
        t_hold();
        t_clamp();
        t_mode_latch();
        t_pad();
        t_power();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule